// File: doc/BRIEF.md
# Dual Delay-Line Fine-Time Merger

This block takes the calibrated results of two independent tapped delay lines that sampled the same timing event. It places the event on one virtual line that is about twice as fine. For each line, the calibration store upstream supplies the hit code and two cumulative boundaries. The first is the calibrated time at the bin's lower edge, read at code minus one. The second is the time at its upper edge, read at the code itself. All times are normalized to one reference clock period, and full scale is the all-ones word.

The two lines' bins overlap, and their intersection is one step of the merged line. With m and n bins per period, the merged line has m+n-1 steps. The step begins at the later of the two lower edges and ends at the earlier of the two upper edges. The block computes this step for each conversion as it arrives, so no merged table is stored. The two lines also need no controlled offset between them. The output is the step midpoint with one extra fractional bit, together with the step width. An error flag marks calibration data whose intersection is empty.

Top module: `tdc_pair_merge`

## Requirements
- R1: The merged step begin is the larger of the two conditioned lower edges.
- R2: The merged step end is the smaller of the two conditioned upper edges.
- R3: When end >= begin, `out_fine` equals begin + end, which is the midpoint with one fractional bit (LSB worth half a calibration unit), 11 bits wide.
- R4: A line whose code is 0 has its lower edge taken as 0, whatever its lower-edge input holds.
- R5: A line whose code equals that line's top code (parameter, 88 for line A and 90 for line B by default) has its upper edge taken as 1023 (full scale), whatever its upper-edge input holds.
- R6: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high, and low otherwise.
- R7: When end < begin, `out_err` is 1, `out_fine` is 2 x begin, and `out_width` is 0. Otherwise `out_err` is 0.
- R8: After synchronous reset, `out_valid`, `out_err`, `out_fine` and `out_width` are all 0.
- R9: In cycles where `out_valid` is low, `out_fine`, `out_width` and `out_err` keep their previous values.
- R10: When end >= begin, `out_width` equals end - begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Boundaries and codes are valid this cycle |
| code_a | input | 8 | Hit code of line A |
| lo_a | input | 10 | Line A cumulative lower edge (value at code-1) |
| hi_a | input | 10 | Line A cumulative upper edge (value at code) |
| code_b | input | 8 | Hit code of line B |
| lo_b | input | 10 | Line B cumulative lower edge |
| hi_b | input | 10 | Line B cumulative upper edge |
| out_valid | output | 1 | Result valid |
| out_fine | output | 11 | Merged step midpoint, one fractional bit |
| out_width | output | 10 | Merged step width |
| out_err | output | 1 | Empty intersection (inconsistent calibration) |

## Verification
The assertions assume that `in_valid` is held low while reset is asserted. The bench meets this by driving every input to zero until reset is released. The assertions make no assumption about boundary values, because the error path is meant to cover inconsistent pairs. The stimulus therefore mixes overlapping bin pairs, pairs that touch at one point, and deliberately disjoint pairs. It drives codes at 0 and at each line's top code, with the edge inputs set to values that would change the result if they were not overridden.

// File: rtl/tdc_merge_pkg.sv
package tdc_merge_pkg;
  localparam int DEF_WORD_W = 10;
  localparam int DEF_CODE_W = 8;

  typedef enum logic {
    LINE_A = 1'b0,
    LINE_B = 1'b1
  } line_id_e;

  localparam int N_LINES = 2;
endpackage

// File: rtl/tdc_edge_cond.sv
module tdc_edge_cond
  import tdc_merge_pkg::*;
#(
  parameter int W        = DEF_WORD_W,
  parameter int CODE_W   = DEF_CODE_W,
  parameter int TOP_CODE = 88
) (
  input  logic [CODE_W-1:0] code,
  input  logic [W-1:0]      lo_raw,
  input  logic [W-1:0]      hi_raw,
  output logic [W-1:0]      lo_edge,
  output logic [W-1:0]      hi_edge
);
  localparam logic [W-1:0]      FULL  = {W{1'b1}};
  localparam logic [CODE_W-1:0] TOP_C = CODE_W'(TOP_CODE);

  always_comb begin
    lo_edge = (code == '0)    ? '0   : lo_raw;
    hi_edge = (code == TOP_C) ? FULL : hi_raw;
  end
endmodule

// File: rtl/tdc_bound_stage.sv
module tdc_bound_stage
  import tdc_merge_pkg::*;
#(
  parameter int W = DEF_WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] lo_a,
  input  logic [W-1:0] hi_a,
  input  logic [W-1:0] lo_b,
  input  logic [W-1:0] hi_b,
  output logic         v_q,
  output logic [W-1:0] beg_q,
  output logic [W-1:0] end_q,
  output logic         bad_q
);
  logic [W-1:0] beg_c, end_c;
  line_id_e     beg_src, end_src;

  always_comb begin
    beg_src = (lo_a >= lo_b) ? LINE_A : LINE_B;
    end_src = (hi_a <= hi_b) ? LINE_A : LINE_B;
    beg_c   = (beg_src == LINE_A) ? lo_a : lo_b;
    end_c   = (end_src == LINE_A) ? hi_a : hi_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      beg_q <= '0;
      end_q <= '0;
      bad_q <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        beg_q <= beg_c;
        end_q <= end_c;
        bad_q <= (end_c < beg_c);
      end
    end
  end
endmodule

// File: rtl/tdc_mid_stage.sv
module tdc_mid_stage
  import tdc_merge_pkg::*;
#(
  parameter int W = DEF_WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         v_in,
  input  logic [W-1:0] beg_in,
  input  logic [W-1:0] end_in,
  input  logic         bad_in,
  output logic         v_q,
  output logic [W:0]   fine_q,
  output logic [W-1:0] width_q,
  output logic         err_q
);
  logic [W:0]   sum_c;
  logic [W-1:0] diff_c;

  always_comb begin
    sum_c  = {1'b0, beg_in} + {1'b0, end_in};
    diff_c = end_in - beg_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= 1'b0;
      fine_q  <= '0;
      width_q <= '0;
      err_q   <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        err_q <= bad_in;
        if (bad_in) begin
          fine_q  <= {beg_in, 1'b0};
          width_q <= '0;
        end else begin
          fine_q  <= sum_c;
          width_q <= diff_c;
        end
      end
    end
  end
endmodule

// File: rtl/tdc_pair_merge.sv
module tdc_pair_merge
  import tdc_merge_pkg::*;
#(
  parameter int W      = DEF_WORD_W,
  parameter int CODE_W = DEF_CODE_W,
  parameter int TOP_A  = 88,
  parameter int TOP_B  = 90
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] code_a,
  input  logic [W-1:0]      lo_a,
  input  logic [W-1:0]      hi_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic [W-1:0]      lo_b,
  input  logic [W-1:0]      hi_b,
  output logic              out_valid,
  output logic [W:0]        out_fine,
  output logic [W-1:0]      out_width,
  output logic              out_err
);
  logic [CODE_W-1:0] code_v [N_LINES];
  logic [W-1:0]      lo_v   [N_LINES];
  logic [W-1:0]      hi_v   [N_LINES];
  logic [W-1:0]      lo_e   [N_LINES];
  logic [W-1:0]      hi_e   [N_LINES];

  always_comb begin
    code_v[0] = code_a; lo_v[0] = lo_a; hi_v[0] = hi_a;
    code_v[1] = code_b; lo_v[1] = lo_b; hi_v[1] = hi_b;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    localparam int TOPG = (g == 0) ? TOP_A : TOP_B;
    tdc_edge_cond #(.W(W), .CODE_W(CODE_W), .TOP_CODE(TOPG)) u_cond (
      .code    (code_v[g]),
      .lo_raw  (lo_v[g]),
      .hi_raw  (hi_v[g]),
      .lo_edge (lo_e[g]),
      .hi_edge (hi_e[g])
    );
  end

  logic         s1_v, s1_bad;
  logic [W-1:0] s1_beg, s1_end;

  tdc_bound_stage #(.W(W)) u_bound (
    .clk   (clk),
    .rst   (rst),
    .v_in  (in_valid),
    .lo_a  (lo_e[0]),
    .hi_a  (hi_e[0]),
    .lo_b  (lo_e[1]),
    .hi_b  (hi_e[1]),
    .v_q   (s1_v),
    .beg_q (s1_beg),
    .end_q (s1_end),
    .bad_q (s1_bad)
  );

  tdc_mid_stage #(.W(W)) u_mid (
    .clk     (clk),
    .rst     (rst),
    .v_in    (s1_v),
    .beg_in  (s1_beg),
    .end_in  (s1_end),
    .bad_in  (s1_bad),
    .v_q     (out_valid),
    .fine_q  (out_fine),
    .width_q (out_width),
    .err_q   (out_err)
  );
endmodule

// File: rtl/tdc_pair_merge_chk.sv
module tdc_pair_merge_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W:0]   out_fine,
  input logic [W-1:0] out_width,
  input logic         out_err
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid);  // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##2 !out_valid);  // R6
  AST_ERR_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst) out_err |-> (out_width == '0));  // R7
  AST_ERR_EVEN_FINE: assert property (@(posedge clk) disable iff (rst) out_err |-> (out_fine[0] == 1'b0));  // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !out_valid |-> ($stable(out_fine) && $stable(out_width) && $stable(out_err)));  // R9
  AST_MID_PARITY: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_err) |-> (out_fine[0] == out_width[0]));  // R10
endmodule

bind tdc_pair_merge tdc_pair_merge_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_fine  (out_fine),
  .out_width (out_width),
  .out_err   (out_err)
);

// File: tb/tb_tdc_pair_merge.sv
module tb_tdc_pair_merge;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int CW = 8;
  localparam int TOPA = 88;
  localparam int TOPB = 90;
  localparam int FULLS = 1023;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] code_a = '0, code_b = '0;
  logic [W-1:0]  lo_a = '0, hi_a = '0, lo_b = '0, hi_b = '0;
  logic          out_valid, out_err;
  logic [W:0]    out_fine;
  logic [W-1:0]  out_width;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_pair_merge #(.W(W), .CODE_W(CW), .TOP_A(TOPA), .TOP_B(TOPB)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .code_a(code_a), .lo_a(lo_a), .hi_a(hi_a),
    .code_b(code_b), .lo_b(lo_b), .hi_b(hi_b),
    .out_valid(out_valid), .out_fine(out_fine),
    .out_width(out_width), .out_err(out_err)
  );

  typedef struct {
    bit    v;
    int    fine;
    int    width;
    bit    err;
    string tag;
  } exp_t;

  exp_t  pipe[$];
  int    applied = 0;
  int    fails = 0;
  int    last_fine = 0, last_width = 0;
  bit    last_err = 0;
  bit    done = 0;

  task automatic note_fail(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic compare(exp_t e);
    applied++;
    if (e.v) begin
      last_fine = e.fine; last_width = e.width; last_err = e.err;
    end
    if (out_valid !== e.v) note_fail("R6", "valid", int'(out_valid), int'(e.v));
    if (int'(out_fine) != last_fine) note_fail(e.tag, "fine", int'(out_fine), last_fine);
    if (int'(out_width) != last_width) note_fail(e.tag, "width", int'(out_width), last_width);
    if (out_err !== last_err) note_fail(e.tag, "err", int'(out_err), int'(last_err));
  endtask

  // One clock: compare the vector driven two cycles ago, then drive a new one
  task automatic step(bit v, string tag, int ca, int la, int ha, int cb, int lb, int hb);
    exp_t e;
    int lea, hea, leb, heb, bg, en;
    @(negedge clk);
    if (pipe.size() == 2) compare(pipe.pop_front());
    lea = (ca == 0) ? 0 : la;          // R4
    leb = (cb == 0) ? 0 : lb;
    hea = (ca == TOPA) ? FULLS : ha;   // R5
    heb = (cb == TOPB) ? FULLS : hb;
    bg  = (lea > leb) ? lea : leb;     // R1
    en  = (hea < heb) ? hea : heb;     // R2
    e.v = v; e.tag = tag;
    if (en < bg) begin                 // R7
      e.err = 1; e.fine = 2 * bg; e.width = 0;
    end else begin                     // R3, R10
      e.err = 0; e.fine = bg + en; e.width = en - bg;
    end
    pipe.push_back(e);
    in_valid = v;
    code_a = CW'(ca); lo_a = W'(la); hi_a = W'(ha);
    code_b = CW'(cb); lo_b = W'(lb); hi_b = W'(hb);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, "R9", 5, 300, 700, 5, 100, 900);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    note_fail("watchdog", "timeout", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    applied++;
    if (out_valid !== 1'b0 || out_err !== 1'b0 || out_fine !== '0 || out_width !== '0)
      note_fail("R8", "reset outputs", int'(out_fine), 0);
    rst = 1'b0;

    step(1, "R1", 10, 200, 220, 11, 210, 230);   // begin from line B
    step(1, "R1", 10, 215, 240, 11, 205, 250);   // begin from line A
    step(1, "R2", 20, 400, 430, 21, 405, 420);   // end from line B
    step(1, "R3", 30, 600, 624, 31, 610, 640);
    step(1, "R10", 40, 700, 700, 41, 700, 720);  // zero-width touch
    idle(3);                                     // R9 hold
    step(1, "R4", 0, 900, 20, 0, 800, 24);       // lower edges forced to 0
    step(1, "R4", 0, 999, 30, 1, 12, 45);
    step(1, "R5", TOPA, 1000, 5, TOPB, 1001, 7); // upper edges forced full
    step(1, "R5", TOPA, 1010, 0, 50, 1000, 1020);
    step(1, "R7", 12, 500, 520, 13, 530, 540);   // disjoint -> error
    idle(2);
    step(1, "R7", 12, 800, 810, 13, 100, 120);
    step(1, "R6", 14, 300, 320, 15, 310, 330);
    step(0, "R6", 14, 300, 320, 15, 310, 330);
    step(1, "R6", 14, 300, 320, 15, 310, 330);

    for (int t = 0; t < 400; t++) begin
      int ca, cb, la, lb, ha, hb;
      bit v;
      v  = ($urandom_range(0, 3) != 0);
      ca = $urandom_range(0, TOPA);
      cb = $urandom_range(0, TOPB);
      la = $urandom_range(0, 990);
      lb = la + $urandom_range(0, 30) - 15;
      if (lb < 0) lb = 0;
      ha = la + $urandom_range(0, 30);
      hb = lb + $urandom_range(0, 30);
      if (hb > FULLS) hb = FULLS;
      step(v, (t % 2 == 0) ? "R3" : "R7", ca, la, ha, cb, lb, hb);
    end
    idle(3);
    finish_run();
  end
endmodule